// File: doc/BRIEF.md
# Keyboard and Border I/O Port

This block is a legacy-style peripheral on an 8-bit CPU I/O bus. It decodes only address bit 0, so it responds whenever that bit is 0. It therefore appears at half of the 16-bit I/O space, and every such address is an alias of the same port. The CPU places the accumulator or the upper half of a register pair on address lines 15..8. This makes the high address byte an active-low selector of keyboard matrix rows.

On a read the block returns the merged state of the selected rows of an 8x5 key matrix, with keys active low. On a write it latches a border colour field and a speaker level. A port-select output shows when an I/O cycle falls within the decoded space. Scan timing, debouncing and video generation are outside the block.

Top module: `kbd_border_port`

## Requirements
- R1: `port_sel` is 1 exactly when `iorq_n` is 0 and `addr[0]` is 0, whatever `addr[15:1]` holds. Reads and writes at any such address act identically.
- R2: During a read cycle (`iorq_n`=0, `rd_n`=0, `addr[0]`=0), a 0 on `addr[8+r]` selects matrix row r. `dout[c]` for c in 0..4 is the AND of `keys[r*5+c]` over all selected rows. A key value of 0 means pressed and 1 means released.
- R3: During a read cycle with `addr[15:8]` = 8'hFF (no row selected), `dout[4:0]` reads 5'b11111.
- R4: During a read cycle, `dout[7:5]` reads 3'b111.
- R5: Outside a read cycle (`iorq_n`, `rd_n` or `addr[0]` high), `dout` is 8'hFF.
- R6: On a rising `clk` edge where `iorq_n`=0, `wr_n`=0 and `addr[0]`=0, `border` takes `din[2:0]` and `speaker` takes `din[4]`.
- R7: A write strobe with `addr[0]`=1 or with `iorq_n`=1 leaves `border` and `speaker` unchanged.
- R8: While `rst_n` is 0, and after its release until the first write, `border` is 0 and `speaker` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | I/O address bus |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from the CPU |
| keys | input | 40 | Key matrix state, bit r*5+c is row r column c, 0 = pressed |
| dout | output | 8 | Read data to the CPU |
| border | output | 3 | Latched border colour |
| speaker | output | 1 | Latched speaker level |
| port_sel | output | 1 | I/O cycle falls in the decoded space |

## Verification
The bench builds the block with its default parameters: a 16-bit address, eight rows of five keys, a 3-bit colour field and the speaker in data bit 4. With these values, single-row, multi-row, all-row and no-row selections are all reachable from the high address byte. Aliasing is exercised by hitting the port through high bytes and odd low-byte patterns that differ only outside bit 0. Ignored writes are confirmed on the `border` and `speaker` outputs right after the strobe.

// File: rtl/kbport_pkg.sv
package kbport_pkg;

  // Default geometry of the port
  localparam int KB_ADDR_W   = 16;
  localparam int KB_DATA_W   = 8;
  localparam int KB_ROWS     = 8;
  localparam int KB_COLS     = 5;
  localparam int KB_BORDER_W = 3;
  localparam int KB_SPK_POS  = 4;

  // Decoded view of one bus cycle
  typedef struct packed {
    logic hit;   // address inside the decoded space with a request
    logic rd;    // read cycle aimed at this port
    logic wr;    // write cycle aimed at this port
  } kbport_cyc_t;

  function automatic kbport_cyc_t classify(input logic iorq_n, input logic rd_n,
                                           input logic wr_n, input logic sel_bit);
    kbport_cyc_t c;
    c.hit = ~iorq_n & ~sel_bit;
    c.rd  = c.hit & ~rd_n;
    c.wr  = c.hit & ~wr_n;
    return c;
  endfunction

endpackage

// File: rtl/kbport_decode.sv
module kbport_decode
  import kbport_pkg::*;
(
  input  logic        sel_bit,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  output kbport_cyc_t cyc
);

  always_comb cyc = classify(iorq_n, rd_n, wr_n, sel_bit);

endmodule

// File: rtl/kbport_rowscan.sv
module kbport_rowscan #(
  parameter int ROWS = 8,
  parameter int COLS = 5
) (
  input  logic [ROWS*COLS-1:0] keys,
  input  logic [ROWS-1:0]      row_sel_n,
  output logic [COLS-1:0]      cols
);

  logic [COLS-1:0] masked [ROWS];

  // An unselected row contributes all ones, so it never masks a key
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign masked[r] = row_sel_n[r] ? {COLS{1'b1}} : keys[r*COLS +: COLS];
  end

  always_comb begin
    cols = {COLS{1'b1}};
    for (int r = 0; r < ROWS; r++) cols = cols & masked[r];
  end

endmodule

// File: rtl/kbport_outreg.sv
module kbport_outreg #(
  parameter int BORDER_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [BORDER_W-1:0] border_d,
  input  logic                spk_d,
  output logic [BORDER_W-1:0] border,
  output logic                speaker
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      border  <= '0;
      speaker <= 1'b0;
    end else if (wr_fire) begin
      border  <= border_d;
      speaker <= spk_d;
    end
  end

  AST_WR_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> border == $past(border_d)); // R6
  AST_WR_SPK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> speaker == $past(spk_d)); // R6
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(border) && $stable(speaker)); // R7
  AST_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> border == '0 && !speaker); // R8

endmodule

// File: rtl/kbd_border_port.sv
module kbd_border_port
  import kbport_pkg::*;
#(
  parameter int ADDR_W   = KB_ADDR_W,
  parameter int DATA_W   = KB_DATA_W,
  parameter int ROWS     = KB_ROWS,
  parameter int COLS     = KB_COLS,
  parameter int BORDER_W = KB_BORDER_W,
  parameter int SPK_POS  = KB_SPK_POS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [DATA_W-1:0]    din,
  input  logic [ROWS*COLS-1:0] keys,
  output logic [DATA_W-1:0]    dout,
  output logic [BORDER_W-1:0]  border,
  output logic                 speaker,
  output logic                 port_sel
);

  localparam int ROW_LSB = ADDR_W - ROWS;
  localparam int PAD_W   = DATA_W - COLS;

  kbport_cyc_t     cyc;
  logic            rd_fire;
  logic            wr_fire;
  logic [COLS-1:0] key_cols;

  // Only referenced partly; collected here so nothing dangles
  logic unused_bus;
  assign unused_bus = ^{addr, din};

  kbport_decode u_decode (
    .sel_bit (addr[0]),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .cyc     (cyc)
  );

  assign port_sel = cyc.hit;
  assign rd_fire  = cyc.rd;
  assign wr_fire  = cyc.wr;

  kbport_rowscan #(.ROWS(ROWS), .COLS(COLS)) u_rowscan (
    .keys      (keys),
    .row_sel_n (addr[ADDR_W-1:ROW_LSB]),
    .cols      (key_cols)
  );

  kbport_outreg #(.BORDER_W(BORDER_W)) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .border_d (din[BORDER_W-1:0]),
    .spk_d    (din[SPK_POS]),
    .border   (border),
    .speaker  (speaker)
  );

  always_comb begin
    if (rd_fire) dout = {{PAD_W{1'b1}}, key_cols};
    else         dout = {DATA_W{1'b1}};
  end

  AST_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> &dout[DATA_W-1:COLS]); // R4
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |-> &dout); // R5
  AST_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && &addr[ADDR_W-1:ROW_LSB] |-> &dout[COLS-1:0]); // R3
  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire || wr_fire) |-> port_sel && !iorq_n); // R1

endmodule

// File: tb/kbd_border_port_test.sv
module kbd_border_port_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] dout;
    logic       sel;
    logic [2:0] border;
    logic       spk;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'hFFFF;
  logic        iorq_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  din = 8'h00;
  logic [39:0] keys = '1;
  logic [7:0]  dout;
  logic [2:0]  border;
  logic        speaker;
  logic        port_sel;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [2:0] m_border = 3'd0;
  logic       m_spk = 1'b0;

  kbd_border_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .keys(keys), .dout(dout), .border(border),
    .speaker(speaker), .port_sel(port_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference read value, walked key by key
  function automatic logic [7:0] ref_read(input logic [15:0] a, input logic rq_n,
                                          input logic r_n, input logic [39:0] k);
    logic [7:0] v;
    v = 8'hFF;
    if (rq_n || r_n || a[0]) return v;
    for (int col = 0; col < 5; col++)
      for (int row = 0; row < 8; row++)
        if (!a[8+row] && !k[row*5+col]) v[col] = 1'b0;
    return v;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.dout   = ref_read(addr, iorq_n, rd_n, keys);
    e.sel    = (iorq_n == 1'b0) && (addr[0] == 1'b0);
    e.border = m_border;
    e.spk    = m_spk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (dout !== e.dout || port_sel !== e.sel || border !== e.border || speaker !== e.spk) begin
        fails++;
        $display("FAIL %s: got dout=%h sel=%b border=%0d spk=%b, expected dout=%h sel=%b border=%0d spk=%b",
                 t, dout, port_sel, border, speaker, e.dout, e.sel, e.border, e.spk);
      end
    end
  end

  task automatic do_read(input logic [15:0] a, input logic rq_n, input logic r_n, input string tag);
    @(posedge clk); #1;
    addr = a; iorq_n = rq_n; rd_n = r_n; wr_n = 1'b1;
    push(tag);
    @(negedge clk); #1;
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic rq_n, input logic [7:0] d, input string tag);
    @(posedge clk); #1;
    addr = a; iorq_n = rq_n; wr_n = 1'b0; rd_n = 1'b1; din = d;
    if (!rq_n && !a[0]) begin
      m_border = d[2:0];
      m_spk    = d[4];
    end
    @(posedge clk); #1;
    iorq_n = 1'b1; wr_n = 1'b1;
    push(tag);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push("R8 reset state");
    @(negedge clk); #1;

    // row 2 keys 0 and 3 down, row 7 key 0 (space) down
    keys = '1;
    keys[2*5+0] = 1'b0;
    keys[2*5+3] = 1'b0;
    keys[7*5+0] = 1'b0;
    do_read(16'hFBFE, 1'b0, 1'b0, "R2 row 2 only");
    do_read(16'h7FFE, 1'b0, 1'b0, "R2 space row 7");
    do_read(16'h7AFE, 1'b0, 1'b0, "R2 rows 0,2,7 merged");
    do_read(16'hFFFE, 1'b0, 1'b0, "R3 no row selected");
    do_read(16'hFBFF, 1'b0, 1'b0, "R5 addr bit0 high");
    do_read(16'hFBFE, 1'b1, 1'b0, "R5 no request");
    do_read(16'hFBFE, 1'b0, 1'b1, "R5 no read strobe");
    do_read(16'hFB00, 1'b0, 1'b0, "R1 alias low byte 00");
    do_read(16'hFB12, 1'b0, 1'b0, "R1 alias low byte 12");
    do_read(16'h1234, 1'b0, 1'b1, "R1 select without strobe");

    // varied matrices, all rows and single rows, top bits per R4
    for (int i = 0; i < 8; i++) begin
      keys = {keys[38:0], keys[39] ^ keys[20] ^ keys[1] ^ 1'b1};
      do_read(16'h00FE, 1'b0, 1'b0, "R4 all rows pattern");
      do_read({~(8'h01 << i), 8'h00}, 1'b0, 1'b0, "R2 single row sweep");
    end

    do_write(16'h00FE, 1'b0, 8'h15, "R6 write border 5 speaker 1");
    do_write(16'h7EFE, 1'b0, 8'h02, "R6 alias write border 2");
    do_write(16'h00FF, 1'b0, 8'h17, "R7 odd address write ignored");
    do_write(16'h00FE, 1'b1, 8'h1F, "R7 no request write ignored");
    do_write(16'hA5A4, 1'b0, 8'hEF, "R6 write border 7 speaker 0");

    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule